// File: doc/BRIEF.md
# Negate Execute Unit

This unit executes one integer operation: the two's-complement negate of a 64-bit general-purpose register. Each instruction arrives as a 32-bit word with a valid strobe. Bit positions are counted MSB-first, so instruction bit 0 is `insn_i[31]`. The unit decodes the word and drives the source register index straight back out to the register file. In the next cycle it returns the operand and a registered destination write.

Two flags in the word extend the operation. The overflow-enable flag writes the overflow bit and sets the sticky summary-overflow bit. The record flag writes a 4-bit condition field from a signed compare of the result against zero. Any valid word whose opcode pair is not the negate pair is flagged as illegal and produces no write. Carry is never touched.

Top module: `neg_exec_unit`

## Requirements
- R1: A valid word is legal only when `insn_i[31:26]` equals 31 and `insn_i[9:1]` equals 104. Any other valid word gives `illegal_o`=1 with `rd_we_o`, `xer_we_o` and `cr_we_o` all 0.
- R2: `dst_idx_o` is taken from `insn_i[25:21]`. `src_idx_o` follows `insn_i[20:16]` in the same cycle, combinationally. The contents of `insn_i[15:11]` change no output.
- R3: For a legal word, `rd_we_o`=1 and `result_o` equals 0 minus `src_i`, modulo 2^64.
- R4: The input 0x8000000000000000 negates to itself. It is the only value that counts as signed overflow.
- R5: When the overflow-enable flag `insn_i[10]` is 1, `xer_we_o`=1, `ov_o` is the overflow condition, and `so_o` is `so_i` OR overflow. When the flag is 0, `xer_we_o`=0 and `ov_o`/`so_o` echo `ov_i`/`so_i`.
- R6: When the record flag `insn_i[0]` is 1, `cr_we_o`=1 and `cr_o[3:1]` is {LT, GT, EQ} from a signed 64-bit compare of the result with zero. Exactly one of these three bits is set.
- R7: `cr_o[0]` holds the summary-overflow value after this instruction's own overflow update.
- R8: Outputs appear one clock after `valid_i`. A cycle without `valid_i` gives `valid_o`=0, `illegal_o`=0 and no write enables.
- R9: Asynchronous reset (`rst_ni` low) clears `valid_o`, `illegal_o` and all write enables.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid |
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Source register value |
| ov_i | input | 1 | Current overflow bit |
| so_i | input | 1 | Current summary-overflow bit |
| src_idx_o | output | 5 | Source register index (combinational) |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Valid word did not decode |
| dst_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write enable |
| result_o | output | 64 | Negated value |
| xer_we_o | output | 1 | Status bits write enable |
| ov_o | output | 1 | New overflow bit |
| so_o | output | 1 | New summary-overflow bit |
| cr_we_o | output | 1 | Condition field write enable |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `src_i`, `so_i` and `insn_i` are known values whenever `valid_i` is high. They also relate each registered output to the inputs sampled exactly one edge earlier, so any cycle-to-cycle change of the inputs is allowed. The bench changes inputs only on falling edges and draws every field from a seeded generator. It biases the operand toward zero, the most-negative value and its neighbours. Both flags and `so_i` are drawn freely, and the opcode fields are corrupted often enough to reach the illegal path.

// File: rtl/neg_pkg.sv
package neg_pkg;
  localparam int unsigned XLEN       = 64;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned CR_W       = 4;
  localparam logic [5:0]  PRIMARY_OP = 6'd31;
  localparam logic [8:0]  EXT_OP     = 9'd104;

  typedef struct packed {
    logic             legal;
    logic             ov_en;
    logic             rec;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
  } neg_dec_t;
endpackage

// File: rtl/neg_decode.sv
module neg_decode
  import neg_pkg::*;
(
  input  logic [31:0] insn_i,
  output neg_dec_t    dec_o
);
  // MSB-first numbering: bit k of the word is insn_i[31-k]
  logic [5:0] prim;
  logic [8:0] ext;

  assign prim = insn_i[31:26];
  assign ext  = insn_i[9:1];

  always_comb begin
    dec_o.legal = (prim == PRIMARY_OP) && (ext == EXT_OP);
    dec_o.ov_en = insn_i[10];
    dec_o.rec   = insn_i[0];
    dec_o.dst   = insn_i[25:21];
    dec_o.src   = insn_i[20:16];
  end
endmodule

// File: rtl/neg_negate.sv
module neg_negate #(
  parameter int unsigned W       = 64,
  parameter bit          USE_SUB = 1'b0
) (
  input  logic [W-1:0] src_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  generate
    if (USE_SUB) begin : g_sub
      assign res_o = '0 - src_i;
    end else begin : g_inv
      assign res_o = ~src_i + W'(1);
    end
  endgenerate

  // sole signed-overflow input
  assign ovf_o = (src_i == MOST_NEG);

  always_comb begin
    assert (ovf_o == (res_o == src_i && src_i != '0))
      else $error("AST_FIXED_POINT"); // R4
  end
endmodule

// File: rtl/neg_flags.sv
module neg_flags #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] res_i,
  input  logic         ovf_i,
  input  logic         ov_en_i,
  input  logic         ov_i,
  input  logic         so_i,
  output logic         ov_o,
  output logic         so_o,
  output logic [3:0]   cr_o
);
  logic lt, eq, gt;

  always_comb begin
    if (ov_en_i) begin
      ov_o = ovf_i;
      so_o = so_i | ovf_i;
    end else begin
      ov_o = ov_i;
      so_o = so_i;
    end
  end

  assign lt   = res_i[W-1];
  assign eq   = (res_i == '0);
  assign gt   = !lt && !eq;
  assign cr_o = {lt, gt, eq, so_o};

  always_comb begin
    assert ($countones(cr_o[3:1]) == 1) else $error("AST_CR_ONE_HOT"); // R6
    assert (!(so_i && !so_o)) else $error("AST_SO_NEVER_CLEARS"); // R5
  end
endmodule

// File: rtl/neg_exec_unit.sv
module neg_exec_unit
  import neg_pkg::*;
#(
  parameter int unsigned W       = XLEN,
  parameter bit          USE_SUB = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic [W-1:0]     src_i,
  input  logic             ov_i,
  input  logic             so_i,
  output logic [IDX_W-1:0] src_idx_o,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [IDX_W-1:0] dst_idx_o,
  output logic             rd_we_o,
  output logic [W-1:0]     result_o,
  output logic             xer_we_o,
  output logic             ov_o,
  output logic             so_o,
  output logic             cr_we_o,
  output logic [CR_W-1:0]  cr_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  neg_dec_t        dec;
  logic [W-1:0]    res_d;
  logic            ovf_d;
  logic            ov_d, so_d;
  logic [CR_W-1:0] cr_d;
  logic            fire;

  neg_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  neg_negate #(.W(W), .USE_SUB(USE_SUB)) u_neg (
    .src_i (src_i),
    .res_o (res_d),
    .ovf_o (ovf_d)
  );

  neg_flags #(.W(W)) u_flags (
    .res_i   (res_d),
    .ovf_i   (ovf_d),
    .ov_en_i (dec.ov_en),
    .ov_i    (ov_i),
    .so_i    (so_i),
    .ov_o    (ov_d),
    .so_o    (so_d),
    .cr_o    (cr_d)
  );

  assign src_idx_o = dec.src;
  assign fire      = valid_i && dec.legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_we_o   <= 1'b0;
      xer_we_o  <= 1'b0;
      cr_we_o   <= 1'b0;
      dst_idx_o <= '0;
      result_o  <= '0;
      ov_o      <= 1'b0;
      so_o      <= 1'b0;
      cr_o      <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && !dec.legal;
      rd_we_o   <= fire;
      xer_we_o  <= fire && dec.ov_en;
      cr_we_o   <= fire && dec.rec;
      if (valid_i) begin
        dst_idx_o <= dec.dst;
        result_o  <= res_d;
        ov_o      <= ov_d;
        so_o      <= so_d;
        cr_o      <= cr_d;
      end
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(rd_we_o || xer_we_o || cr_we_o || illegal_o)); // R8
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(rd_we_o || xer_we_o || cr_we_o)); // R1
  AST_NEGATE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (result_o + $past(src_i)) == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xer_we_o |-> ov_o == (result_o == MOST_NEG)); // R4
  AST_SO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xer_we_o |-> so_o == ($past(so_i) || ov_o)); // R5
  AST_CR_SO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> cr_o[0] == so_o); // R7
  AST_CR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> cr_o[3:1] == {result_o[W-1], !result_o[W-1] && result_o != '0, result_o == '0}); // R6
endmodule

// File: tb/neg_exec_unit_test.sv
`timescale 1ns/1ps
module neg_exec_unit_test;
  localparam logic [63:0] MIN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_i = '0;
  logic        ov_i = 1'b0, so_i = 1'b0;
  logic [4:0]  src_idx_o, dst_idx_o;
  logic        valid_o, illegal_o, rd_we_o, xer_we_o, ov_o, so_o, cr_we_o;
  logic [63:0] result_o;
  logic [3:0]  cr_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  neg_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i), .src_i(src_i),
    .ov_i(ov_i), .so_i(so_i), .src_idx_o(src_idx_o), .valid_o(valid_o),
    .illegal_o(illegal_o), .dst_idx_o(dst_idx_o), .rd_we_o(rd_we_o),
    .result_o(result_o), .xer_we_o(xer_we_o), .ov_o(ov_o), .so_o(so_o),
    .cr_we_o(cr_we_o), .cr_o(cr_o)
  );

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] ra,
                                     logic [4:0] rb, logic oe, logic [8:0] xo, logic rc);
    return {po, rt, ra, rb, oe, xo, rc};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one word on a falling edge, check at the following falling edge
  task automatic run(logic v, logic [31:0] w, logic [63:0] s, logic ovi, logic soi);
    logic        legal, oe, rc, ovf, so_n, ov_n;
    logic [63:0] r;
    logic [3:0]  cr;
    @(negedge clk);
    valid_i = v; insn_i = w; src_i = s; ov_i = ovi; so_i = soi;
    #1;
    chk(src_idx_o == w[20:16], "R2", 64'(src_idx_o), 64'(w[20:16]));
    legal = (w[31:26] == 6'd31) && (w[9:1] == 9'd104);
    oe = w[10]; rc = w[0];
    r = 64'd0 - s;
    ovf = (s == MIN);
    ov_n = oe ? ovf : ovi;
    so_n = oe ? (soi | ovf) : soi;
    cr = {$signed(r) < 0, $signed(r) > 0, r == 64'd0, so_n};
    @(negedge clk);
    if (!v) begin
      chk({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o} == 5'b0, "R8",
          64'({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o}), 64'd0);
    end else if (!legal) begin
      chk({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o} == 5'b11000, "R1",
          64'({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o}), 64'b11000);
    end else begin
      chk(valid_o && !illegal_o && rd_we_o, "R8", 64'({valid_o, illegal_o, rd_we_o}), 64'b101);
      chk(dst_idx_o == w[25:21], "R2", 64'(dst_idx_o), 64'(w[25:21]));
      chk(result_o == r, ovf ? "R4" : "R3", result_o, r);
      chk(xer_we_o == oe, "R5", 64'(xer_we_o), 64'(oe));
      chk({ov_o, so_o} == {ov_n, so_n}, "R5", 64'({ov_o, so_o}), 64'({ov_n, so_n}));
      chk(cr_we_o == rc, "R6", 64'(cr_we_o), 64'(rc));
      if (rc) begin
        chk(cr_o[3:1] == cr[3:1], "R6", 64'(cr_o), 64'(cr));
        chk(cr_o[0] == cr[0], "R7", 64'(cr_o), 64'(cr));
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] s;
    logic [31:0] w;
    logic [63:0] r0;
    void'($urandom(32'h5eed_0107));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o} == 5'b0, "R9",
        64'({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o}), 64'd0);
    rst_ni = 1'b1;

    // directed corners
    run(1, mk(31, 3, 4, 0, 1, 104, 1), MIN, 0, 0);                // R4 overflow, R7 SO from overflow
    run(1, mk(31, 1, 2, 0, 1, 104, 1), 64'd0, 1, 0);              // EQ, ov cleared
    run(1, mk(31, 1, 2, 0, 0, 104, 1), 64'd5, 1, 1);              // LT, SO passthrough
    run(1, mk(31, 9, 2, 0, 1, 104, 1), 64'hFFFF_FFFF_FFFF_FFFF, 0, 1); // GT, sticky SO kept
    run(1, mk(31, 7, 8, 0, 0, 104, 0), MIN, 1, 0);                // R4 without OE: no status write
    run(1, mk(31, 7, 8, 0, 1, 104, 0), MIN + 64'd1, 0, 0);        // neighbour: no overflow
    run(1, mk(30, 7, 8, 0, 1, 104, 1), 64'd3, 0, 0);              // R1 bad primary
    run(1, mk(31, 7, 8, 0, 1, 105, 1), 64'd3, 0, 0);              // R1 bad extended
    run(0, mk(31, 7, 8, 0, 1, 104, 1), 64'd3, 0, 0);              // R8 idle
    // R2: second-source field has no effect
    run(1, mk(31, 12, 13, 5'h00, 1, 104, 1), 64'h1234, 0, 0);
    r0 = result_o;
    run(1, mk(31, 12, 13, 5'h1F, 1, 104, 1), 64'h1234, 0, 0);
    chk(result_o == r0, "R2", result_o, r0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 6)
        0: s = MIN;
        1: s = 64'd0;
        2: s = MIN + 64'($urandom % 3) - 64'd1;
        3: s = 64'($urandom % 4);
        default: s = {$urandom, $urandom};
      endcase
      w = mk(6'd31, 5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 9'd104, 1'($urandom));
      if ($urandom % 8 == 0) w[31:26] = 6'($urandom);
      if ($urandom % 8 == 0) w[9:1] = 9'($urandom);
      run(($urandom % 10) != 0, w, s, 1'($urandom), 1'($urandom));
    end

    // R9: asynchronous reset mid-stream
    @(negedge clk);
    valid_i = 1'b1; insn_i = mk(31, 1, 1, 0, 1, 104, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o} == 5'b0, "R9",
        64'({valid_o, illegal_o, rd_we_o, xer_we_o, cr_we_o}), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule